// File: doc/BRIEF.md
# I2C Stuck-Bus Recovery Controller

This block is the digital control for a two-sided I2C buffer. It watches the SDA and SCL levels seen on the output side. When either line stays low for longer than a set timeout, it assumes a slave has lost sync and is holding the bus. It then cuts the link between the two sides and pulls its open-drain fault line low.

Once the link is cut, the controller acts as a master of its own on the isolated side. It sends a short, bounded burst of SCL pulses at a fixed rate, so that a slave stuck partway through a byte can shift out its remaining bits and let go of SDA. At the end of every pulse it looks at the bus. If both lines read high, it ends the burst, releases the fault line and restores the link. If the burst runs out and the bus is still not free, the output side stays cut off. Low-time detection then starts again, so a further burst follows after another full timeout.

Timeout, half-period and pulse count are parameters counted in clock cycles. With the defaults and a 200 MHz clock they give a 30 ms timeout and sixteen pulses at roughly 8.5 kHz. The half-period must be at least 3 cycles so that the synchronised SCL level settles inside each released half.

Top module: `busRecoveryCtl`

## Requirements
- R1: After reset, connEn is 1, faultN is 1 and sclPullDn is 0.
- R2: Each line passes through a two-flop synchroniser. A stuck bus is declared after TIMEOUT_CYC consecutive synchronised cycles in which SDA or SCL is low. connEn falls exactly TIMEOUT_CYC+2 clock edges after the first edge that samples a low input.
- R3: Whenever both synchronised lines read high, the low-time count restarts. A low spell shorter than the timeout, even when two such spells come close together, raises no fault.
- R4: On the edge where a stuck bus is declared, connEn goes to 0 and faultN goes to 0 (0 means the fault line is pulled low), and sclPullDn goes to 1 to start the first pulse.
- R5: Each pulse holds sclPullDn at 1 for HALF_CYC cycles and then at 0 for HALF_CYC cycles. One burst contains at most PULSES pulses.
- R6: At the last cycle of each released half, if both synchronised lines read high, the burst stops. On the next edge connEn and faultN return to 1, so a burst ended after K pulses holds faultN low for exactly 2*K*HALF_CYC cycles.
- R7: If the bus is still not clear at the end of pulse number PULSES, the controller enters isolation: connEn 0, faultN 0, sclPullDn 0.
- R8: While isolated, once both lines read high the link is restored. connEn rises 3 edges after the first edge that samples both lines high.
- R9: While isolated, if a line stays low for TIMEOUT_CYC further cycles, a new burst starts and sclPullDn rises TIMEOUT_CYC edges after isolation began.
- R10: A bus held low on SCL alone (SDA high) is detected and recovered in the same way as a low SDA.
- R11: sclPullDn is never 1 while connEn is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sdaLine | input | 1 | Output-side SDA level (asynchronous) |
| sclLine | input | 1 | Output-side SCL level (asynchronous) |
| connEn | output | 1 | 1 = the two bus sides are linked |
| sclPullDn | output | 1 | 1 = pull output-side SCL low |
| faultN | output | 1 | Open-drain fault: 0 = pulled low, 1 = released |

## Verification
The bench sets the moment of detection to the exact edge, so an off-by-one in the low-time counter or one sync stage too many or too few shows up as connEn falling a cycle early or late. Two near-timeout low spells separated by a brief high catch a counter that does not restart on an idle bus: such a counter would raise a false fault. Slaves that let go after a chosen number of pulses, on SDA and on SCL, expose a design that checks the bus at the wrong phase or keeps clocking after the bus clears, because the fault-low duration and the pulse count would both be wrong. A bus that never clears tests the sixteen-pulse limit, the isolated state, the restored link after a late release, and the fresh burst after a second timeout. A design that kept clocking, reconnected too soon or never retried would give a different pulse count or SCL level at the checked edge.

// File: rtl/busRecPkg.sv
package busRecPkg;

  typedef enum logic [1:0] {
    ST_LINKED   = 2'd0,
    ST_CLOCKING = 2'd1,
    ST_ISOLATED = 2'd2
  } recState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrIdle;   // hold the low-time counter at zero
    logic runBurst;  // run the pulse generator
  } recStrobe_t;

endpackage

// File: rtl/busRecSync.sv
module busRecSync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], rawIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/busRecDatapath.sv
module busRecDatapath
  import busRecPkg::*;
#(
  parameter int TIMEOUT_CYC = 6_000_000,
  parameter int HALF_CYC    = 11_765,
  parameter int PULSES      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaRaw,
  input  logic       sclRaw,
  input  recStrobe_t strobe,
  output logic       busHigh,
  output logic       lowTimeout,
  output logic       pulseEnd,
  output logic       lastPulse,
  output logic       pullLow
);
  localparam int LOW_W = $clog2(TIMEOUT_CYC + 1);
  localparam int PH_W  = $clog2(HALF_CYC + 1);
  localparam int PC_W  = $clog2(PULSES + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(TIMEOUT_CYC - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(HALF_CYC - 1);
  localparam logic [PC_W-1:0]  PC_LAST  = PC_W'(PULSES - 1);

  logic [1:0] rawLines, syncLines;
  assign rawLines = {sclRaw, sdaRaw};

  for (genvar i = 0; i < 2; i++) begin : g_sync
    busRecSync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[i]), .syncOut(syncLines[i])
    );
  end

  assign busHigh = &syncLines;

  // low-time counter, saturating at the last count
  logic [LOW_W-1:0] lowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowCnt <= '0;
    else if (strobe.clrIdle || busHigh) lowCnt <= '0;
    else if (lowCnt != LOW_LAST)      lowCnt <= lowCnt + 1'b1;
  end
  assign lowTimeout = !busHigh && (lowCnt == LOW_LAST);

  // pulse generator: low half (halfSel=0) then released half (halfSel=1)
  logic [PH_W-1:0] phaseCnt;
  logic            halfSel;
  logic [PC_W-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      halfSel  <= 1'b0;
      pulseCnt <= '0;
    end else if (!strobe.runBurst) begin
      phaseCnt <= '0;
      halfSel  <= 1'b0;
      pulseCnt <= '0;
    end else if (phaseCnt == PH_LAST) begin
      phaseCnt <= '0;
      halfSel  <= !halfSel;
      if (halfSel) pulseCnt <= pulseCnt + 1'b1;
    end else begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign pulseEnd  = strobe.runBurst && halfSel && (phaseCnt == PH_LAST);
  assign lastPulse = (pulseCnt == PC_LAST);
  assign pullLow   = strobe.runBurst && !halfSel;

  // a burst only ever starts from an expired low-time count
  assert_burst_after_timeout_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.runBurst) |-> $past(lowTimeout));

  // the pulse generator never outlives PULSES pulses
  assert_pulse_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseEnd && lastPulse) |=> !pullLow);
endmodule

// File: rtl/busRecControl.sv
module busRecControl
  import busRecPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busHigh,
  input  logic       lowTimeout,
  input  logic       pulseEnd,
  input  logic       lastPulse,
  output recStrobe_t strobe,
  output logic       linked
);
  recState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_LINKED;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LINKED:   if (lowTimeout) stateNext = ST_CLOCKING;
      ST_CLOCKING: if (pulseEnd) begin
                     if (busHigh)        stateNext = ST_LINKED;
                     else if (lastPulse) stateNext = ST_ISOLATED;
                   end
      ST_ISOLATED: if (busHigh)         stateNext = ST_LINKED;
                   else if (lowTimeout) stateNext = ST_CLOCKING;
      default:     stateNext = ST_LINKED;
    endcase
  end

  assign strobe.runBurst = (state == ST_CLOCKING);
  assign strobe.clrIdle  = (state == ST_CLOCKING);
  assign linked          = (state == ST_LINKED);

  // link is restored only from a bus seen idle
  assert_reconnect_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linked) |-> $past(busHigh));

  // an exhausted burst on a busy bus leaves the side cut off, clock released
  assert_isolate_after_burst_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runBurst && pulseEnd && lastPulse && !busHigh) |=> (!linked && !strobe.runBurst));
endmodule

// File: rtl/busRecoveryCtl.sv
module busRecoveryCtl
  import busRecPkg::*;
#(
  parameter int TIMEOUT_CYC = 6_000_000,
  parameter int HALF_CYC    = 11_765,
  parameter int PULSES      = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic sdaLine,
  input  logic sclLine,
  output logic connEn,
  output logic sclPullDn,
  output logic faultN
);
  recStrobe_t strobe;
  logic busHigh, lowTimeout, pulseEnd, lastPulse, pullLow, linked;

  busRecDatapath #(
    .TIMEOUT_CYC(TIMEOUT_CYC), .HALF_CYC(HALF_CYC), .PULSES(PULSES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdaRaw(sdaLine), .sclRaw(sclLine),
    .strobe(strobe), .busHigh(busHigh), .lowTimeout(lowTimeout),
    .pulseEnd(pulseEnd), .lastPulse(lastPulse), .pullLow(pullLow)
  );

  busRecControl u_ctl (
    .clk(clk), .rstN(rstN), .busHigh(busHigh), .lowTimeout(lowTimeout),
    .pulseEnd(pulseEnd), .lastPulse(lastPulse), .strobe(strobe), .linked(linked)
  );

  assign connEn    = linked;
  assign faultN    = linked;
  assign sclPullDn = pullLow;

  assert_no_pull_while_linked_R11: assert property (@(posedge clk) disable iff (!rstN)
    sclPullDn |-> !connEn);
endmodule

// File: tb/sim_busRecoveryCtl.sv
`timescale 1ns/1ps
module sim_busRecoveryCtl;
  localparam int T = 200;
  localparam int H = 10;
  localparam int P = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic connEn, sclPullDn, faultN;
  logic sdaLine, sclLine;

  // slave model
  logic stuckSda = 1'b0, stuckScl = 1'b0;
  int   relK = 1000, pulseBase = 0, faultBase = 0;
  int   pulseTotal = 0, faultTotal = 0;
  logic prevPull = 1'b0;
  logic holdSda, holdScl;

  assign holdSda = stuckSda && ((pulseTotal - pulseBase) < relK);
  assign holdScl = stuckScl && ((pulseTotal - pulseBase) < relK);
  assign sdaLine = !holdSda;
  assign sclLine = !(sclPullDn || holdScl);

  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  busRecoveryCtl #(.TIMEOUT_CYC(T), .HALF_CYC(H), .PULSES(P)) u0 (
    .clk(clk), .rstN(rstN), .sdaLine(sdaLine), .sclLine(sclLine),
    .connEn(connEn), .sclPullDn(sclPullDn), .faultN(faultN)
  );

  always @(negedge clk) begin
    if (prevPull && !sclPullDn) pulseTotal <= pulseTotal + 1;
    if (!faultN) faultTotal <= faultTotal + 1;
    prevPull <= sclPullDn;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic snap();
    pulseBase = pulseTotal;
    faultBase = faultTotal;
  endtask

  task automatic waitLinked(input int bound);
    for (int i = 0; i < bound && !connEn; i++) tick(1);
  endtask

  task automatic testReset();
    tick(3);
    check(connEn == 1'b1,    "R1 connEn",    connEn, 1);
    check(faultN == 1'b1,    "R1 faultN",    faultN, 1);
    check(sclPullDn == 1'b0, "R1 sclPullDn", sclPullDn, 0);
  endtask

  task automatic testShortLows();
    int drops = 0, pulls = 0;
    relK = 1000; snap();
    stuckSda = 1'b1;
    for (int i = 0; i < T - 5; i++) begin tick(1); drops += !connEn; pulls += sclPullDn; end
    stuckSda = 1'b0;
    for (int i = 0; i < 3; i++) begin tick(1); drops += !connEn; pulls += sclPullDn; end
    stuckSda = 1'b1;
    for (int i = 0; i < T - 5; i++) begin tick(1); drops += !connEn; pulls += sclPullDn; end
    stuckSda = 1'b0;
    for (int i = 0; i < 10; i++) begin tick(1); drops += !connEn; pulls += sclPullDn; end
    check(drops == 0, "R3 no fault on short lows", drops, 0);
    check(pulls == 0, "R11 no pull while linked", pulls, 0);
  endtask

  task automatic testRecoverSda();
    relK = 3; snap();
    stuckSda = 1'b1;
    tick(T + 1);
    check(connEn == 1'b1, "R2 still linked at T+1", connEn, 1);
    tick(1);
    check(connEn == 1'b0,    "R2 unlinked at T+2", connEn, 0);
    check(faultN == 1'b0,    "R4 fault low",       faultN, 0);
    check(sclPullDn == 1'b1, "R4 first pulse",     sclPullDn, 1);
    tick(H - 1);
    check(sclPullDn == 1'b1, "R5 low half length", sclPullDn, 1);
    tick(1);
    check(sclPullDn == 1'b0, "R5 released half",   sclPullDn, 0);
    waitLinked(1000);
    check(connEn == 1'b1 && faultN == 1'b1, "R6 relinked", connEn, 1);
    check(pulseTotal - pulseBase == 3, "R6 pulses", pulseTotal - pulseBase, 3);
    check(faultTotal - faultBase == 2 * 3 * H, "R6 fault cycles", faultTotal - faultBase, 2 * 3 * H);
    check(sclPullDn == 1'b0, "R11 pull off after relink", sclPullDn, 0);
    stuckSda = 1'b0;
    tick(5);
  endtask

  task automatic testRecoverScl();
    relK = 5; snap();
    stuckScl = 1'b1;
    waitLinked(1);
    for (int i = 0; i < T + 10 && connEn; i++) tick(1);
    check(connEn == 1'b0, "R10 SCL low detected", connEn, 0);
    waitLinked(1000);
    check(connEn == 1'b1, "R10 relinked", connEn, 1);
    check(pulseTotal - pulseBase == 5, "R10 pulses", pulseTotal - pulseBase, 5);
    check(faultTotal - faultBase == 2 * 5 * H, "R10 fault cycles", faultTotal - faultBase, 2 * 5 * H);
    stuckScl = 1'b0;
    tick(5);
  endtask

  task automatic enterIsolation();
    relK = 1000; snap();
    stuckSda = 1'b1;
    for (int i = 0; i < T + 10 && connEn; i++) tick(1);
    tick(2 * P * H);
  endtask

  task automatic testIsolateRelease();
    enterIsolation();
    check(pulseTotal - pulseBase == P, "R5 burst limit", pulseTotal - pulseBase, P);
    check(connEn == 1'b0 && faultN == 1'b0, "R7 isolated", connEn, 0);
    check(sclPullDn == 1'b0, "R7 clock released", sclPullDn, 0);
    tick(5);
    stuckSda = 1'b0;
    tick(2);
    check(connEn == 1'b0, "R8 not yet linked", connEn, 0);
    tick(1);
    check(connEn == 1'b1 && faultN == 1'b1, "R8 relinked", connEn, 1);
    tick(5);
  endtask

  task automatic testRearm();
    enterIsolation();
    tick(T - 1);
    check(sclPullDn == 1'b0, "R9 idle before retry", sclPullDn, 0);
    tick(1);
    check(sclPullDn == 1'b1, "R9 retry burst", sclPullDn, 1);
    stuckSda = 1'b0;
    waitLinked(4 * H);
    check(connEn == 1'b1, "R9 relinked after retry", connEn, 1);
    tick(5);
  endtask

  initial begin
    tick(2);
    rstN = 1'b1;
    testReset();
    testShortLows();
    testRecoverSda();
    testRecoverScl();
    testIsolateRelease();
    testRearm();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule